// File: doc/BRIEF.md
# Multiplexed External Bus Controller

The controller turns single-beat 32-bit read and write requests from an internal port into cycles on a simple external bus for targets such as flash, boot ROM or gate-array logic. Every external cycle has an address phase, marked by a one-clock address-latch strobe, followed by one or more data phases. Each data phase ends when the target raises its transfer-acknowledge input.

Six chip-select windows map the address space. Each window has a base, a mask and a port-size code. A strap input, sampled once after reset, chooses one of two bus modes. In the separate mode, the address goes out on its own lines and the data bus is always 32 bits wide. In the shared mode, the full address goes out on the data lines during the address phase, and each window can use an 8-, 16- or 32-bit port. A 32-bit request to a narrow port is split into sequential beats.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset every chip select is high (inactive) and the strobe, output enable and response are low. The request port is not ready until the first clock edge after reset release.
- R2: A request hits window i when ((addr XOR base_i) AND mask_i) is zero, where a mask bit of 1 means the bit is compared. If several windows hit, the lowest index wins. The active-low chip select of the winner stays low from the address phase through the last data beat, and at most one chip select is low at any time.
- R3: A request that hits no window drives no external cycle. In the next cycle it returns a one-cycle response with the error flag set.
- R4: The strap is captured at the first clock edge after reset release (1 = shared address/data bus, 0 = separate address and data lines). Later changes of the strap have no effect until the next reset.
- R5: The address phase lasts exactly one clock, with the strobe high and the full 32-bit address on the address lines. In shared mode the same address is also driven onto the data lines with the output enable high.
- R6: A read inserts exactly one turnaround clock, with the data output enable low, between the address phase and its first data beat. A write enters its first data beat directly, and the output enable stays high through its data beats.
- R7: The port-size code cs_psize_i[2i+1:2i] selects the width: 00 = 32 bits, 01 = 8 bits, 10 = 16 bits, 11 = 32 bits. In separate mode every window is 32 bits wide.
- R8: A 32-bit request is split into 4 beats on an 8-bit port and 2 beats on a 16-bit port. The most significant part goes first, narrow data uses the low lanes of the data bus, and the address lines advance by the port width in bytes for each beat.
- R9: A data beat ends at a clock edge where the acknowledge is high. Read data is assembled from the low lanes, with later beats forming the less significant parts, and upper unused lanes are ignored.
- R10: If the acknowledge stays low for 255 clocks of one data beat, the access ends with an error response.
- R11: Every access ends with exactly one response cycle, during which all chip selects are inactive. A read with no error returns the assembled data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mux_strap_i | input | 1 | Bus mode strap, 1 = shared address/data |
| cs_base_i | input | 192 | Window base addresses, 32 bits per window |
| cs_mask_i | input | 192 | Window compare masks, 32 bits per window |
| cs_psize_i | input | 12 | Port-size codes, 2 bits per window |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Request address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_err_o | output | 1 | Response error (no window hit or timeout) |
| rsp_rdata_o | output | 32 | Read data |
| cs_n_o | output | 6 | Active-low chip selects |
| ale_o | output | 1 | Address-latch strobe |
| rd_o | output | 1 | High during a read cycle |
| addr_o | output | 32 | Address lines, current beat address |
| ad_o | output | 32 | Data lines out, carrying the address in shared mode |
| ad_oe_o | output | 1 | Data line output enable |
| ad_i | input | 32 | Data lines in |
| ta_i | input | 1 | Transfer acknowledge from target |

## Verification
The embedded assertions check the cycle-level rules on every clock. These rules are the single-clock strobe, at most one active chip select, the output enable low in the clock after a read strobe, the single response cycle with all chip selects released, the error response to a miss, the bounded timeout count and the strap value held after capture. Only the bench scenarios can show the rest. That covers window priority among overlapping windows, the beat count and byte order for each port-size code, address advance between beats, assembly of read data that ignores the upper lanes, the 255-clock timeout and the difference between the two strap modes, all compared clock by clock against a behavioural model.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_TURN, ST_DATA, ST_RSP
  } ebc_state_e;

  typedef enum logic [1:0] {
    PS_W32 = 2'b00, PS_W8 = 2'b01, PS_W16 = 2'b10, PS_W32X = 2'b11
  } port_size_e;
endpackage

// File: rtl/ebc_strap.sv
module ebc_strap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic mode_mux_o,
  output logic mode_valid_o
);
  logic mode_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      mode_q  <= strap_i;
      valid_q <= 1'b1;
    end
  end

  assign mode_mux_o   = mode_q;
  assign mode_valid_o = valid_q;

  a_r4_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> (valid_q && $stable(mode_q)));
endmodule

// File: rtl/ebc_cs_decode.sv
module ebc_cs_decode #(
  parameter int unsigned NUM_CS = 6,
  parameter int unsigned AW     = 32
) (
  input  logic [AW-1:0]        addr_i,
  input  logic [NUM_CS*AW-1:0] base_i,
  input  logic [NUM_CS*AW-1:0] mask_i,
  input  logic [NUM_CS*2-1:0]  psize_i,
  output logic                 hit_o,
  output logic [NUM_CS-1:0]    sel_o,
  output logic [1:0]           psize_o
);
  logic [NUM_CS-1:0] raw;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    assign raw[g] = ((addr_i ^ base_i[g*AW +: AW]) & mask_i[g*AW +: AW]) == '0;
  end

  // lowest index wins
  always_comb begin
    sel_o   = '0;
    psize_o = 2'b00;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (raw[i]) begin
        sel_o      = '0;
        sel_o[i]   = 1'b1;
        psize_o    = psize_i[i*2 +: 2];
      end
    end
  end

  assign hit_o = |raw;
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int unsigned NUM_CS  = 6,
  parameter int unsigned AW      = 32,
  parameter int unsigned TIMEOUT = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mux_mode_i,
  input  logic              mode_valid_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              req_ready_o,
  input  logic              hit_i,
  input  logic [NUM_CS-1:0] sel_i,
  input  logic [1:0]        psize_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              ale_o,
  output logic              rd_o,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     ad_o,
  output logic              ad_oe_o,
  input  logic [DW-1:0]     ad_i,
  input  logic              ta_i
);
  localparam int unsigned TOW = $clog2(TIMEOUT + 1);

  ebc_state_e        state_q;
  port_size_e        lane_q, lane_d;
  logic              we_q, err_q, active;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q, rdata_q, wr_lane;
  logic [NUM_CS-1:0] sel_q;
  logic [1:0]        beats_q;
  logic [TOW-1:0]    to_cnt_q;
  logic [2:0]        step;
  logic              accept;

  assign accept = req_valid_i && req_ready_o;

  always_comb begin
    lane_d = PS_W32;
    if (mux_mode_i) begin
      unique case (psize_i)
        2'b01:   lane_d = PS_W8;
        2'b10:   lane_d = PS_W16;
        default: lane_d = PS_W32;
      endcase
    end
  end

  always_comb begin
    unique case (lane_q)
      PS_W8:   begin step = 3'd1; wr_lane = {24'h0, wdata_q[31:24]}; end
      PS_W16:  begin step = 3'd2; wr_lane = {16'h0, wdata_q[31:16]}; end
      default: begin step = 3'd4; wr_lane = wdata_q; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      lane_q   <= PS_W32;
      we_q     <= 1'b0;
      err_q    <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      sel_q    <= '0;
      beats_q  <= '0;
      to_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          err_q   <= !hit_i;
          rdata_q <= '0;
          if (hit_i) begin
            state_q <= ST_ADDR;
            we_q    <= req_we_i;
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            sel_q   <= sel_i;
            lane_q  <= lane_d;
            beats_q <= (lane_d == PS_W8) ? 2'd3 : (lane_d == PS_W16) ? 2'd1 : 2'd0;
          end else begin
            state_q <= ST_RSP;
          end
        end
        ST_ADDR: begin
          state_q  <= we_q ? ST_DATA : ST_TURN;
          to_cnt_q <= '0;
        end
        ST_TURN: state_q <= ST_DATA;
        ST_DATA: begin
          if (ta_i) begin
            to_cnt_q <= '0;
            addr_q   <= addr_q + AW'(step);
            unique case (lane_q)
              PS_W8:   begin rdata_q <= {rdata_q[23:0], ad_i[7:0]};  wdata_q <= wdata_q << 8;  end
              PS_W16:  begin rdata_q <= {rdata_q[15:0], ad_i[15:0]}; wdata_q <= wdata_q << 16; end
              default: rdata_q <= ad_i;
            endcase
            if (beats_q == 2'd0) state_q <= ST_RSP;
            else beats_q <= beats_q - 2'd1;
          end else if (to_cnt_q == TOW'(TIMEOUT - 1)) begin
            err_q   <= 1'b1;
            state_q <= ST_RSP;
          end else begin
            to_cnt_q <= to_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign active      = (state_q == ST_ADDR) || (state_q == ST_TURN) || (state_q == ST_DATA);
  assign req_ready_o = (state_q == ST_IDLE) && mode_valid_i;
  assign rsp_valid_o = (state_q == ST_RSP);
  assign rsp_err_o   = rsp_valid_o && err_q;
  assign rsp_rdata_o = (rsp_valid_o && !err_q && !we_q) ? rdata_q : '0;
  assign cs_n_o      = active ? ~sel_q : '1;
  assign ale_o       = (state_q == ST_ADDR);
  assign rd_o        = active && !we_q;
  assign addr_o      = active ? addr_q : '0;
  assign ad_oe_o     = (ale_o && mux_mode_i) || ((state_q == ST_DATA) && we_q);
  assign ad_o        = (ale_o && mux_mode_i) ? addr_q :
                       ((state_q == ST_DATA) && we_q) ? wr_lane : '0;

  a_r5_ale_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  a_r2_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  a_r6_read_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && rd_o) |=> !ad_oe_o);
  a_r11_rsp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r11_cs_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (&cs_n_o));
  a_r3_miss_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !hit_i) |=> (rsp_valid_o && rsp_err_o && !ale_o));
  a_r10_to_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_cnt_q < TOW'(TIMEOUT));
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl #(
  parameter int unsigned NUM_CS  = 6,
  parameter int unsigned AW      = 32,
  parameter int unsigned TIMEOUT = 255
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mux_strap_i,
  input  logic [NUM_CS*AW-1:0] cs_base_i,
  input  logic [NUM_CS*AW-1:0] cs_mask_i,
  input  logic [NUM_CS*2-1:0]  cs_psize_i,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_we_i,
  input  logic [AW-1:0]        req_addr_i,
  input  logic [31:0]          req_wdata_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_err_o,
  output logic [31:0]          rsp_rdata_o,
  output logic [NUM_CS-1:0]    cs_n_o,
  output logic                 ale_o,
  output logic                 rd_o,
  output logic [AW-1:0]        addr_o,
  output logic [31:0]          ad_o,
  output logic                 ad_oe_o,
  input  logic [31:0]          ad_i,
  input  logic                 ta_i
);
  logic              mode_mux, mode_valid, hit;
  logic [NUM_CS-1:0] sel;
  logic [1:0]        psize;

  ebc_strap u_strap (
    .clk_i, .rst_ni, .strap_i(mux_strap_i),
    .mode_mux_o(mode_mux), .mode_valid_o(mode_valid)
  );

  ebc_cs_decode #(.NUM_CS(NUM_CS), .AW(AW)) u_dec (
    .addr_i(req_addr_i), .base_i(cs_base_i), .mask_i(cs_mask_i),
    .psize_i(cs_psize_i), .hit_o(hit), .sel_o(sel), .psize_o(psize)
  );

  ebc_seq #(.NUM_CS(NUM_CS), .AW(AW), .TIMEOUT(TIMEOUT)) u_seq (
    .clk_i, .rst_ni,
    .mux_mode_i(mode_mux), .mode_valid_i(mode_valid),
    .req_valid_i, .req_we_i, .req_addr_i, .req_wdata_i, .req_ready_o,
    .hit_i(hit), .sel_i(sel), .psize_i(psize),
    .rsp_valid_o, .rsp_err_o, .rsp_rdata_o,
    .cs_n_o, .ale_o, .rd_o, .addr_o, .ad_o, .ad_oe_o, .ad_i, .ta_i
  );
endmodule

// File: tb/ext_bus_ctrl_bench.sv
module ext_bus_ctrl_bench;
  localparam int NCS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b1;
  logic [NCS*32-1:0] base, mask;
  logic [NCS*2-1:0]  psz;
  logic req_valid = 1'b0, req_we = 1'b0, ready;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic rsp_valid, rsp_err, ale, rd, ad_oe;
  logic [31:0] rsp_rdata, addr, ad_out;
  logic [31:0] ad_in = '0;
  logic ta = 1'b0;
  logic [NCS-1:0] cs_n;

  int checks = 0, failures = 0, cycles = 0;
  bit mode_mux;

  always #2.5 clk = ~clk;

  ext_bus_ctrl u_ext_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mux_strap_i(strap),
    .cs_base_i(base), .cs_mask_i(mask), .cs_psize_i(psz),
    .req_valid_i(req_valid), .req_ready_o(ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .cs_n_o(cs_n), .ale_o(ale), .rd_o(rd), .addr_o(addr),
    .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in), .ta_i(ta)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic int model_cs(input logic [31:0] a);
    for (int i = 0; i < NCS; i++)
      if (((a ^ base[i*32 +: 32]) & mask[i*32 +: 32]) == 32'h0) return i;
    return -1;
  endfunction

  function automatic int model_bytes(input int cs);
    logic [1:0] c;
    if (!mode_mux) return 4;
    c = psz[cs*2 +: 2];
    return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 4;
  endfunction

  function automatic logic [31:0] lmask(input int nb);
    return (nb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (nb * 8)) - 32'h1);
  endfunction

  function automatic logic [31:0] tgt(input logic [31:0] a, input int nb);
    return ((a * 32'h0101_0101) ^ 32'hC3A5_5A3C) & lmask(nb);
  endfunction

  task automatic do_reset(input bit s);
    @(negedge clk);
    rst_n = 1'b0; strap = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mode_mux = s;
    chk("R1 cs_n idle", 32'(cs_n), 32'(6'h3F));
    chk("R1 ale idle", 32'(ale), 0);
    chk("R1 rsp idle", 32'(rsp_valid), 0);
    chk("R1 oe idle", 32'(ad_oe), 0);
    chk("R4 not ready before strap", 32'(ready), 0);
    tick();
    chk("R4 ready after strap", 32'(ready), 1);
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        input int wait_n);
    int cs, nb, beats;
    logic [31:0] exp_rd, ba, lane;
    logic [5:0] exp_cs;
    bit to;
    cs = model_cs(a);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    chk("R1 ready", 32'(ready), 1);
    tick();
    req_valid = 1'b0;
    if (cs < 0) begin
      chk("R3 miss rsp", 32'(rsp_valid), 1);
      chk("R3 miss err", 32'(rsp_err), 1);
      chk("R3 miss no cs", 32'(cs_n), 32'(6'h3F));
      chk("R3 miss no ale", 32'(ale), 0);
      tick();
      chk("R11 rsp single", 32'(rsp_valid), 0);
      return;
    end
    exp_cs = ~(6'h1 << cs);
    nb = model_bytes(cs);
    beats = 4 / nb;
    chk("R5 ale", 32'(ale), 1);
    chk("R2 cs", 32'(cs_n), 32'(exp_cs));
    chk("R5 addr lines", addr, a);
    chk("R5 oe", 32'(ad_oe), 32'(mode_mux));
    if (mode_mux) chk("R5 shared addr", ad_out, a);
    tick();
    if (!we) begin
      chk("R6 turn oe", 32'(ad_oe), 0);
      chk("R5 ale one clock", 32'(ale), 0);
      chk("R2 cs turn", 32'(cs_n), 32'(exp_cs));
      tick();
    end
    exp_rd = '0; ba = a; to = 0;
    for (int b = 0; b < beats && !to; b++) begin
      for (int k = 0; ; k++) begin
        chk("R8 beat addr", addr, ba);
        chk("R6 data oe", 32'(ad_oe), 32'(we));
        chk("R2 cs data", 32'(cs_n), 32'(exp_cs));
        chk("R5 ale low", 32'(ale), 0);
        if (we) begin
          lane = (wd >> (32 - nb * 8 * (b + 1))) & lmask(nb);
          chk("R8 write lane", ad_out, lane);
        end
        if (k == wait_n) begin
          ta = 1'b1;
          ad_in = tgt(ba, nb) | (~lmask(nb) & 32'hEEEE_EEEE);
          exp_rd = (nb == 4) ? tgt(ba, nb) : ((exp_rd << (nb * 8)) | tgt(ba, nb));
        end
        tick();
        ta = 1'b0; ad_in = '0;
        if (k == wait_n) break;
        if (k == 254) begin to = 1; break; end
      end
      ba = ba + nb;
    end
    chk("R11 rsp valid", 32'(rsp_valid), 1);
    chk(to ? "R10 timeout err" : "R9 no err", 32'(rsp_err), 32'(to));
    chk("R11 cs released", 32'(cs_n), 32'(6'h3F));
    if (!we && !to) chk("R9 read data", rsp_rdata, exp_rd);
    tick();
    chk("R11 rsp single", 32'(rsp_valid), 0);
  endtask

  initial begin
    // windows: 0 32-bit, 1 8-bit, 2 16-bit, 3 code 11, 4 wide 8-bit, 5 overlapped by 4
    for (int i = 0; i < 4; i++) begin
      base[i*32 +: 32] = 32'(i) << 28;
      mask[i*32 +: 32] = 32'hFFF0_0000;
    end
    base[4*32 +: 32] = 32'h4000_0000; mask[4*32 +: 32] = 32'hF000_0000;
    base[5*32 +: 32] = 32'h4010_0000; mask[5*32 +: 32] = 32'hFFF0_0000;
    psz = {2'b10, 2'b01, 2'b11, 2'b10, 2'b01, 2'b00};

    do_reset(1'b1);
    access(0, 32'h0000_0040, 0, 0);              // R7 32-bit read
    access(1, 32'h0000_0044, 32'hDEAD_BEEF, 2);  // R6 write
    access(0, 32'h1000_0100, 0, 1);              // R7 R8 8-bit read
    access(1, 32'h1000_0200, 32'h1234_5678, 0);  // R8 8-bit write order
    access(0, 32'h2000_0010, 0, 3);              // R7 16-bit read
    access(1, 32'h2000_0020, 32'hA1B2_C3D4, 1);  // R8 16-bit write
    access(0, 32'h3000_0000, 0, 0);              // R7 code 11
    access(0, 32'h4010_0008, 0, 0);              // R2 priority to window 4
    access(1, 32'h8000_0000, 32'h1, 0);          // R3 miss
    strap = 1'b0;                                // R4 ignored after capture
    access(0, 32'h1000_0300, 0, 0);
    access(0, 32'h2000_0400, 0, 1000);           // R10 timeout
    access(0, 32'h0000_0080, 0, 0);

    do_reset(1'b0);                              // R4 separate mode
    access(0, 32'h1000_0100, 0, 1);              // R7 single 32-bit beat
    access(1, 32'h2000_0020, 32'h0BAD_F00D, 0);
    strap = 1'b1;
    access(0, 32'h4000_0010, 0, 0);
    access(0, 32'h9000_0000, 0, 0);              // R3

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule